// File: doc/BRIEF.md
# Wilkinson Conversion and Event Memory Controller

This controller sequences the digital side of a 36-channel charge and time front end through three phases. While acquiring, it advances a bunch-crossing counter once per clock. It stores the trigger pattern and the counter value for every clock in which at least one channel triggered, up to a fixed number of events. Clocks with no trigger store nothing.

Conversion starts on command. For each stored event it runs one full ramp of a binary counter and presents that counter in Gray code to every channel at once. The first clock in which a channel's end-of-ramp comparator is high freezes that Gray value for the channel. At terminal count the whole row goes into the result memory. Each entry is the binary code plus the gain path the channel reported. A channel that never fired is given the all-ones code.

Readout starts when the previous chip in a daisy chain finishes. It sends the chip identifier, then every stored event, most significant bit first, with a transmit-enable qualifier. It ends with a one-clock pulse that starts the next chip.

Top module: `wilk_evt_ctrl`

## Requirements
- R1: After reset, ramp_on, tx_on, ser_out, ram_full, no_trig and end_ro are 0 and gray_cnt is 0.
- R2: In acquisition, each clock in which trig_in is non-zero stores trig_in and the bunch counter as a new event. The counter is 0 in the first acquisition clock and rises by 1 every acquisition clock. A clock with trig_in all zero stores no event.
- R3: ram_full rises once DEPTH (16) events are stored. Triggers after that are dropped.
- R4: A conversion command with no stored event sets no_trig and skips the ramp. no_trig stays high until the next start_acq.
- R5: During conversion ramp_on is 1 and conv_slot gives the event index. Each event takes exactly 2^CW clocks. gray_cnt starts at 0 and changes by exactly one bit per clock. It is 0 whenever ramp_on is 0.
- R6: A channel's result is the binary value of the count shown in the first ramp clock in which its eor_in is high. It is stored with the gain_in bit sampled in that clock (1 = high-gain path).
- R7: A channel whose eor_in stays low for the whole ramp stores code all-ones with gain bit 0.
- R8: Readout sends chip_id (IDW bits, MSB first). It then sends each stored event in storage order: the BW-bit bunch counter (MSB first), then channels 0 to NCH-1, each as hit bit, gain bit and CW-bit code (MSB first).
- R9: ser_out is valid exactly while tx_on is 1, one bit per clock. end_ro is a single-clock pulse in the clock after the last bit, with tx_on already 0.
- R10: start_conv is obeyed only during acquisition. start_ro is obeyed only after conversion has finished. tx_on and ramp_on are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_id | input | IDW | Identifier sent at the head of the readout |
| start_acq | input | 1 | Begin acquisition, clearing stored events |
| start_conv | input | 1 | End acquisition and begin conversion |
| start_ro | input | 1 | Begin readout (end_ro of the previous chip) |
| trig_in | input | NCH | Per-channel trigger comparators |
| eor_in | input | NCH | Per-channel end-of-ramp comparators |
| gain_in | input | NCH | Per-channel gain path in use (1 = high gain) |
| gray_cnt | output | CW | Shared Gray-coded ramp count |
| ramp_on | output | 1 | Conversion ramp running |
| conv_slot | output | log2(DEPTH) | Event being converted |
| ram_full | output | 1 | Event memory full |
| no_trig | output | 1 | Conversion requested with no stored event |
| tx_on | output | 1 | Serial data valid |
| ser_out | output | 1 | Serial data |
| end_ro | output | 1 | Readout finished, hand-off pulse |

## Verification
The bench targets a channel that fires in the very first ramp clock and one that fires only in the terminal clock. A latch that is late by a clock, or that misses the write in the terminal clock, returns a code off by one or drops a result to all-ones with the wrong gain bit. Trigger-free clocks inside the acquisition pattern catch a design that stores empty events or lets the bunch counter skip. A seventeenth and eighteenth trigger catch overwriting or a counter wrap once memory is full. A run with no trigger at all must produce a header-only frame, and a stray readout command during acquisition must not start the serializer early.

// File: rtl/wilk_evt_ctrl.sv
module wilk_evt_ctrl #(
  parameter int NCH   = 36,
  parameter int CW    = 12,
  parameter int DEPTH = 16,
  parameter int BW    = 12,
  parameter int IDW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDW-1:0]           chip_id,
  input  logic                     start_acq,
  input  logic                     start_conv,
  input  logic                     start_ro,
  input  logic [NCH-1:0]           trig_in,
  input  logic [NCH-1:0]           eor_in,
  input  logic [NCH-1:0]           gain_in,
  output logic [CW-1:0]            gray_cnt,
  output logic                     ramp_on,
  output logic [$clog2(DEPTH)-1:0] conv_slot,
  output logic                     ram_full,
  output logic                     no_trig,
  output logic                     tx_on,
  output logic                     ser_out,
  output logic                     end_ro
);
  localparam int SW  = $clog2(DEPTH);
  localparam int NW  = $clog2(DEPTH + 1);
  localparam int RW  = CW + 1;
  localparam int CHW = CW + 2;
  localparam int FW  = BW + NCH * CHW;
  localparam int PW  = $clog2(FW + IDW + 1);
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_CONV, S_WAIT, S_READ} st_t;

  st_t              st;
  logic [NW-1:0]    nevt;
  logic [BW-1:0]    bcid;
  logic [CW-1:0]    bcnt;
  logic [SW-1:0]    slot;
  logic             hdr;
  logic [PW-1:0]    bpos;
  logic [NCH-1:0]   hit_m [DEPTH];
  logic [BW-1:0]    bc_m  [DEPTH];
  logic [NCH*RW-1:0] res_m [DEPTH];
  logic [CW-1:0]    lat_g [NCH];
  logic [NCH-1:0]   lat_v, lat_gn;
  logic [NCH*RW-1:0] row_w;
  logic [FW-1:0]    frame;
  logic             last_slot, wr_acq, ramp_end, hbit, fbit;

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign gray_cnt  = bcnt ^ (bcnt >> 1);
  assign ramp_on   = (st == S_CONV);
  assign conv_slot = slot;
  assign ram_full  = (nevt == NW'(DEPTH));
  assign tx_on     = (st == S_READ);
  assign last_slot = ((NW'(slot) + NW'(1)) == nevt);
  assign wr_acq    = (st == S_ACQ) && !start_conv && (|trig_in) && !ram_full;
  assign ramp_end  = (st == S_CONV) && (bcnt == CMAX);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (lat_v[c])       row_w[c*RW +: RW] = {lat_gn[c], g2b(lat_g[c])};
      else if (eor_in[c]) row_w[c*RW +: RW] = {gain_in[c], g2b(gray_cnt)};
      else                row_w[c*RW +: RW] = {1'b0, CMAX};
    end
  end

  always_comb begin
    frame[FW-1 -: BW] = bc_m[slot];
    for (int c = 0; c < NCH; c++)
      frame[FW-BW-1-c*CHW -: CHW] = {hit_m[slot][c], res_m[slot][c*RW +: RW]};
  end

  always_comb begin
    hbit = 1'b0;
    fbit = 1'b0;
    for (int i = 0; i < IDW; i++) if (bpos == PW'(i)) hbit = chip_id[IDW-1-i];
    for (int i = 0; i < FW; i++)  if (bpos == PW'(i)) fbit = frame[FW-1-i];
  end

  assign ser_out = tx_on & (hdr ? hbit : fbit);

  always_ff @(posedge clk) begin
    if (wr_acq) begin
      hit_m[nevt[SW-1:0]] <= trig_in;
      bc_m[nevt[SW-1:0]]  <= bcid;
    end
    if (ramp_end) res_m[slot] <= row_w;
    for (int c = 0; c < NCH; c++)
      if (st == S_CONV && eor_in[c] && !lat_v[c]) lat_g[c] <= gray_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      nevt    <= '0;
      bcid    <= '0;
      bcnt    <= '0;
      slot    <= '0;
      hdr     <= 1'b0;
      bpos    <= '0;
      no_trig <= 1'b0;
      end_ro  <= 1'b0;
      lat_v   <= '0;
      lat_gn  <= '0;
    end else begin
      end_ro <= 1'b0;
      case (st)
        S_IDLE, S_WAIT: begin
          if (start_acq) begin
            st      <= S_ACQ;
            nevt    <= '0;
            bcid    <= '0;
            no_trig <= 1'b0;
          end else if (st == S_WAIT && start_ro) begin
            st   <= S_READ;
            hdr  <= 1'b1;
            bpos <= '0;
            slot <= '0;
          end
        end
        S_ACQ: begin
          bcid <= bcid + 1'b1;
          if (wr_acq) nevt <= nevt + 1'b1;
          if (start_conv) begin
            slot  <= '0;
            bcnt  <= '0;
            lat_v <= '0;
            if (nevt == '0) begin
              st      <= S_WAIT;
              no_trig <= 1'b1;
            end else begin
              st <= S_CONV;
            end
          end
        end
        S_CONV: begin
          bcnt <= bcnt + 1'b1;
          for (int c = 0; c < NCH; c++)
            if (eor_in[c] && !lat_v[c]) begin
              lat_v[c]  <= 1'b1;
              lat_gn[c] <= gain_in[c];
            end
          if (bcnt == CMAX) begin
            lat_v <= '0;
            slot  <= slot + 1'b1;
            if (last_slot) st <= S_WAIT;
          end
        end
        S_READ: begin
          if (hdr) begin
            if (bpos == PW'(IDW - 1)) begin
              bpos <= '0;
              if (nevt == '0) begin
                st     <= S_IDLE;
                end_ro <= 1'b1;
              end else begin
                hdr <= 1'b0;
              end
            end else begin
              bpos <= bpos + 1'b1;
            end
          end else begin
            if (bpos == PW'(FW - 1)) begin
              bpos <= '0;
              if (last_slot) begin
                st     <= S_IDLE;
                end_ro <= 1'b1;
              end else begin
                slot <= slot + 1'b1;
              end
            end else begin
              bpos <= bpos + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wilk_evt_chk.sv
module wilk_evt_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ramp_on,
  input logic          tx_on,
  input logic          end_ro,
  input logic          no_trig,
  input logic [CW-1:0] gray_cnt
);
  AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) ramp_on && $past(ramp_on) |-> $countones(gray_cnt ^ $past(gray_cnt)) == 1); // R5
  AST_GRAY_PARKED: assert property (@(posedge clk) disable iff (!rst_n) !ramp_on |-> gray_cnt == '0); // R5
  AST_ENDRO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) end_ro |=> !end_ro); // R9
  AST_ENDRO_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n) end_ro |-> !tx_on && $past(tx_on)); // R9
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(tx_on && ramp_on)); // R10
  AST_NOTRIG_NORAMP: assert property (@(posedge clk) disable iff (!rst_n) no_trig |-> !ramp_on); // R4
endmodule

bind wilk_evt_ctrl wilk_evt_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_on(ramp_on), .tx_on(tx_on),
  .end_ro(end_ro), .no_trig(no_trig), .gray_cnt(gray_cnt)
);

// File: tb/tb_wilk_evt_ctrl.sv
`timescale 1ns/1ps
module tb_wilk_evt_ctrl;
  localparam int NCH = 36, CW = 12, DEPTH = 16, BW = 12, IDW = 8;
  localparam int CHW = CW + 2;
  localparam int FW  = BW + NCH * CHW;
  localparam int NEVER = 1 << CW;
  localparam int CAPN = 8400;
  localparam logic [NCH-1:0] ACQ_TAB [8] = '{
    36'h0_0000_0001, 36'h0, 36'hF_0000_0000, 36'h8_1234_5678,
    36'h0, 36'hF_FFFF_FFFF, 36'h0_0000_0010, 36'h0};

  logic clk = 0, rst_n = 0;
  logic [IDW-1:0] chip_id = '0;
  logic start_acq = 0, start_conv = 0, start_ro = 0;
  logic [NCH-1:0] trig_in = '0, eor_in = '0, gain_in = '0;
  logic [CW-1:0] gray_cnt;
  logic ramp_on, ram_full, no_trig, tx_on, ser_out, end_ro;
  logic [3:0] conv_slot;

  int nchk = 0, nerr = 0, cycles = 0, ncap = 0, nexp = 0;
  logic cap [CAPN];
  logic [NCH-1:0] exp_hit [DEPTH];
  int exp_bc [DEPTH];

  wilk_evt_ctrl dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return int'(b);
  endfunction

  function automatic int tgt(input int s, input int c);
    if (c == 5) return NEVER;
    if (c == 7) return NEVER - 1;
    return (s * 331 + c * 97) % NEVER;
  endfunction

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      eor_in[c]  = ramp_on && (g2b(gray_cnt) >= tgt(int'(conv_slot), c));
      gain_in[c] = ((int'(conv_slot) + c) % 2) == 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      nerr++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic longint getbits(input int p, input int n);
    longint v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | longint'(cap[p + i]);
    return v;
  endfunction

  task automatic do_conv(input int n);
    int cyc = 0, bad = 0;
    logic [CW-1:0] prev;
    @(negedge clk) start_conv = 1;
    @(negedge clk) start_conv = 0;
    prev = gray_cnt;
    if (gray_cnt != '0) bad++;
    while (ramp_on && cyc < 70000) begin
      cyc++;
      @(negedge clk);
      if (ramp_on && $countones(gray_cnt ^ prev) != 1) bad++;
      prev = gray_cnt;
    end
    chk(cyc == n * NEVER, "R5", "ramp clocks", cyc, n * NEVER);
    chk(bad == 0, "R5", "gray steps", bad, 0);
    chk(gray_cnt == '0, "R5", "gray parked", gray_cnt, 0);
  endtask

  task automatic do_read();
    int t = 0;
    ncap = 0;
    @(negedge clk) start_ro = 1;
    @(negedge clk) start_ro = 0;
    while (!end_ro && t < 20000) begin
      if (tx_on && ncap < CAPN) begin cap[ncap] = ser_out; ncap++; end
      t++;
      @(negedge clk);
    end
    chk(end_ro && !tx_on, "R9", "end_ro with tx_on low", {end_ro, tx_on}, 2);
    @(negedge clk);
    chk(!end_ro, "R9", "end_ro single clock", end_ro, 0);
  endtask

  task automatic verify(input int n);
    chk(ncap == IDW + n * FW, "R9", "frame length", ncap, IDW + n * FW);
    if (ncap >= IDW) chk(getbits(0, IDW) == chip_id, "R8", "chip id", getbits(0, IDW), chip_id);
    if (ncap == IDW + n * FW) begin
      for (int e = 0; e < n; e++) begin
        int p = IDW + e * FW, bad = 0;
        logic [NCH-1:0] h;
        chk(getbits(p, BW) == exp_bc[e], "R2", "bunch counter", getbits(p, BW), exp_bc[e]);
        for (int c = 0; c < NCH; c++) h[c] = cap[p + BW + c * CHW];
        chk(h == exp_hit[e], "R2", "hit mask", h, exp_hit[e]);
        for (int c = 0; c < NCH; c++) begin
          int q = p + BW + c * CHW;
          if (c != 5) begin
            if (getbits(q + 2, CW) != longint'(tgt(e, c)) || cap[q + 1] != (((e + c) % 2) == 1)) bad++;
          end
        end
        chk(bad == 0, "R6", "latched codes and gain", bad, 0);
        chk(getbits(p + BW + 5 * CHW + 1, CW + 1) == NEVER - 1, "R7", "unfired channel",
            getbits(p + BW + 5 * CHW + 1, CW + 1), NEVER - 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ramp_on && !tx_on && !ser_out && !ram_full && !no_trig && !end_ro && gray_cnt == '0,
        "R1", "outputs in reset", {ramp_on, tx_on, ser_out, ram_full, no_trig, end_ro}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ramp_on && !tx_on && gray_cnt == '0, "R1", "after release", {ramp_on, tx_on}, 0);

    @(negedge clk) start_conv = 1;
    @(negedge clk) start_conv = 0;
    chk(!ramp_on, "R10", "start_conv in idle ignored", ramp_on, 0);
    @(negedge clk) start_ro = 1;
    @(negedge clk) start_ro = 0;
    chk(!tx_on, "R10", "start_ro in idle ignored", tx_on, 0);

    chip_id = 8'hA5;
    nexp = 0;
    @(negedge clk) start_acq = 1;
    @(negedge clk) start_acq = 0;
    for (int i = 0; i < 8; i++) begin
      trig_in = ACQ_TAB[i];
      if (ACQ_TAB[i] != '0) begin exp_hit[nexp] = ACQ_TAB[i]; exp_bc[nexp] = i; nexp++; end
      @(negedge clk);
    end
    trig_in = '0;
    chk(!ram_full && !no_trig, "R3", "not full after table", ram_full, 0);
    do_conv(nexp);
    do_read();
    verify(nexp);

    chip_id = 8'h5E;
    @(negedge clk) start_acq = 1;
    @(negedge clk) start_acq = 0;
    for (int i = 0; i < 18; i++) begin
      trig_in = '1;
      if (i < DEPTH) begin exp_hit[i] = '1; exp_bc[i] = i; end
      @(negedge clk);
      if (i == DEPTH - 2) chk(!ram_full, "R3", "one below full", ram_full, 0);
      if (i == DEPTH - 1) chk(ram_full, "R3", "full at depth", ram_full, 1);
    end
    trig_in = '0;
    chk(ram_full, "R3", "full holds after extra triggers", ram_full, 1);
    do_conv(DEPTH);
    do_read();
    verify(DEPTH);

    chip_id = 8'h3C;
    @(negedge clk) start_acq = 1;
    @(negedge clk) start_acq = 0;
    chk(!ram_full, "R3", "cleared by new acquisition", ram_full, 0);
    @(negedge clk) start_ro = 1;
    @(negedge clk) start_ro = 0;
    chk(!tx_on, "R10", "start_ro in acquisition ignored", tx_on, 0);
    repeat (2) @(negedge clk);
    @(negedge clk) start_conv = 1;
    @(negedge clk) start_conv = 0;
    chk(no_trig && !ramp_on, "R4", "no trigger flagged, no ramp", {no_trig, ramp_on}, 2);
    do_read();
    verify(0);
    chk(no_trig, "R4", "no_trig held after readout", no_trig, 1);
    @(negedge clk) start_acq = 1;
    @(negedge clk) start_acq = 0;
    chk(!no_trig, "R4", "no_trig cleared by start_acq", no_trig, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule